// File: doc/BRIEF.md
# Exception and Privileged-Mode Controller

This unit sits beside a small processor core and owns the privileged machine state. That state has five parts: the saved return PC, the trap cause, the last faulting address, an enable mask for trap sources and a kernel/user mode flag. Each cycle the core can present one instruction. It raises `insn_valid` and supplies the instruction word, its PC and the value of the general register named in the instruction's `rt` field. In the same cycle it flags any of four trap sources: address fault, illegal instruction, arithmetic overflow and system call.

The unit chooses the highest-priority source that the mask enables. For that source it asserts `trap` together with the fixed handler PC in the same cycle. At the next clock edge it saves the PC, the cause and, for address faults only, the faulting address, and it enters kernel mode. The unit also decodes three privileged instructions. The privileged-read instruction returns a privileged register as a general-register write. The privileged-write instruction loads a privileged register. The trap-return instruction drops the unit back to user mode. When any of these three is issued in user mode, it becomes an illegal-instruction source and has no effect.

All pins are plain control and status signals. There is no data stream and no back-pressure: the core must honour `trap` and `gpr_we` in the cycle they appear.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the unit is in kernel mode, every privileged register reads as zero, and `trap` and `gpr_we` are low.
- R2: A privileged instruction has `insn[31:26]`=6'b010000. A read has `insn[25:21]`=0 and selects privileged register `insn[15:11]`. In kernel mode with no trap taken, a read drives `gpr_we`=1, `gpr_waddr`=`insn[20:16]` and `gpr_wdata` to the register value, all in the same cycle. Register 8 is the fault address, 12 the mask, 13 the cause and 14 the saved PC. Any other number reads 0. When `gpr_we` is low, `gpr_waddr` and `gpr_wdata` are 0.
- R3: A write has `insn[25:21]`=4. In kernel mode with no trap taken, it loads `src_gpr_val` into privileged register `insn[15:11]` at the clock edge.
- R4: The cause codes are address fault 4, illegal instruction 10, overflow 12 and syscall 8. A source can trap only when mask bit [code] is 1. A source whose mask bit is clear changes no state and does not assert `trap`.
- R5: When an enabled source is taken, `trap`=1 and `trap_pc`=0x80000080 in the same cycle. At the edge the saved PC becomes `insn_pc`, the cause becomes code<<2 (bits [6:2], all other bits zero), and the mode becomes kernel.
- R6: Among the enabled sources the order of priority is address fault, then illegal instruction, then overflow, then syscall.
- R7: The fault-address register takes `fault_addr` only when an address-fault trap is taken, or through an explicit write. Other traps leave it unchanged.
- R8: A privileged read, write or return issued in user mode counts as an illegal-instruction source. It writes no general register and no privileged register, and it does not change the mode.
- R9: A trap-return (`insn[25]`=1, `insn[5:0]`=6'h10) in kernel mode with no trap taken sets user mode at the clock edge.
- R10: If a trap is taken in the same cycle as a privileged instruction, the instruction is suppressed: no general-register write, no privileged write and no return.
- R11: When `insn_valid` is low, the trap sources and the instruction word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 32 | Instruction word |
| insn_pc | input | 32 | PC of the presented instruction |
| src_gpr_val | input | 32 | Value of the general register in the `rt` field |
| ev_syscall | input | 1 | System-call source |
| ev_overflow | input | 1 | Arithmetic-overflow source |
| ev_illegal | input | 1 | Illegal-instruction source from the core decoder |
| ev_addr_fault | input | 1 | Address-fault source |
| fault_addr | input | 32 | Faulting virtual address |
| trap | output | 1 | Redirect the fetch PC this cycle |
| trap_pc | output | 32 | Handler PC while `trap` is high, otherwise 0 |
| gpr_we | output | 1 | General-register write from a privileged read |
| gpr_waddr | output | 5 | Destination general register |
| gpr_wdata | output | 32 | Value to write |
| kernel_mode | output | 1 | 1 in kernel mode, 0 in user mode |

## Verification
Two functions can meet in one cycle: a trap being taken and a privileged instruction being executed. The bench provokes this by driving an overflow together with a mask write, and a syscall together with a trap-return. Afterwards it reads the mask back and watches the mode flag, so it can judge whether the trap prevailed and the instruction left no trace. Multi-source cycles, and user-mode privileged instructions with the illegal-instruction bit masked off and on, are judged cycle by cycle against a behavioural model.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSRC   = 4;
  localparam int CODE_W = 5;
  localparam int REG_W  = 5;

  // Trap cause codes; position in the source vector sets priority (0 = highest).
  localparam logic [CODE_W-1:0] CODE_ADDR = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ILL  = 5'd10;
  localparam logic [CODE_W-1:0] CODE_OVF  = 5'd12;
  localparam logic [CODE_W-1:0] CODE_SYS  = 5'd8;

  // Privileged register numbers
  localparam logic [REG_W-1:0] PR_BADVA = 5'd8;
  localparam logic [REG_W-1:0] PR_MASK  = 5'd12;
  localparam logic [REG_W-1:0] PR_CAUSE = 5'd13;
  localparam logic [REG_W-1:0] PR_EPC   = 5'd14;

  typedef struct packed {
    logic             is_read;
    logic             is_write;
    logic             is_ret;
    logic [REG_W-1:0] gpr;
    logic [REG_W-1:0] preg;
  } priv_op_t;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      0:       return CODE_ADDR;
      1:       return CODE_ILL;
      2:       return CODE_OVF;
      default: return CODE_SYS;
    endcase
  endfunction
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid,
  input  logic [XLEN-1:0] word,
  output priv_op_t        op
);
  localparam logic [5:0] PRIV_MAJOR = 6'b010000;
  localparam logic [5:0] RET_FUNCT  = 6'h10;

  logic major;

  always_comb begin
    major       = valid && (word[31:26] == PRIV_MAJOR);
    op.is_read  = major && (word[25:21] == 5'd0);
    op.is_write = major && (word[25:21] == 5'd4);
    op.is_ret   = major && word[25] && (word[5:0] == RET_FUNCT);
    op.gpr      = word[20:16];
    op.preg     = word[15:11];
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              valid,
  input  logic [NSRC-1:0]   src,
  input  logic [XLEN-1:0]   mask,
  output logic              take,
  output logic [CODE_W-1:0] code,
  output logic [NSRC-1:0]   grant
);
  logic [NSRC-1:0] enabled;

  for (genvar g = 0; g < NSRC; g++) begin : g_en
    assign enabled[g] = valid && src[g] && mask[src_code(g)];
  end

  always_comb begin
    grant = '0;
    code  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (enabled[i]) begin
        grant = NSRC'(1) << i;
        code  = src_code(i);
      end
    end
    take = |enabled;
  end

  always_comb begin
    assert_single_grant_R6: assert ($onehot0(grant));
    assert_masked_code_R4: assert (!take || mask[code]);
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  input  logic              addr_hit,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   bad_addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_sel,
  input  logic [XLEN-1:0]   wr_val,
  input  logic              ret_en,
  input  logic [REG_W-1:0]  rd_sel,
  output logic [XLEN-1:0]   rd_val,
  output logic [XLEN-1:0]   mask,
  output logic              kernel
);
  logic [XLEN-1:0] epc, cause, badva;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc    <= '0;
      cause  <= '0;
      badva  <= '0;
      mask   <= '0;
      kernel <= 1'b1;
    end else if (take) begin
      epc    <= cur_pc;
      cause  <= XLEN'(code) << 2;
      kernel <= 1'b1;
      if (addr_hit) badva <= bad_addr;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          PR_EPC:   epc   <= wr_val;
          PR_CAUSE: cause <= wr_val;
          PR_BADVA: badva <= wr_val;
          PR_MASK:  mask  <= wr_val;
          default:  ;
        endcase
      end
      if (ret_en) kernel <= 1'b0;
    end
  end

  always_comb begin
    case (rd_sel)
      PR_EPC:   rd_val = epc;
      PR_CAUSE: rd_val = cause;
      PR_BADVA: rd_val = badva;
      PR_MASK:  rd_val = mask;
      default:  rd_val = '0;
    endcase
  end

  assert_trap_enters_kernel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> kernel);
  assert_trap_saves_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> epc == $past(cur_pc));
  assert_return_to_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !take) |=> !kernel);
  assert_badva_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(take && addr_hit) && !(wr_en && !take && wr_sel == PR_BADVA)) |=> $stable(badva));
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0080
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  input  logic [XLEN-1:0]  insn,
  input  logic [XLEN-1:0]  insn_pc,
  input  logic [XLEN-1:0]  src_gpr_val,
  input  logic             ev_syscall,
  input  logic             ev_overflow,
  input  logic             ev_illegal,
  input  logic             ev_addr_fault,
  input  logic [XLEN-1:0]  fault_addr,
  output logic             trap,
  output logic [XLEN-1:0]  trap_pc,
  output logic             gpr_we,
  output logic [REG_W-1:0] gpr_waddr,
  output logic [XLEN-1:0]  gpr_wdata,
  output logic             kernel_mode
);
  priv_op_t          op;
  logic              priv_hit, violation, exec_ok;
  logic [NSRC-1:0]   src, grant;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   mask, rd_val;

  exc_decode #(.XLEN(XLEN)) u_dec (.valid(insn_valid), .word(insn), .op(op));

  assign priv_hit  = op.is_read || op.is_write || op.is_ret;
  assign violation = priv_hit && !kernel_mode;
  assign src       = {ev_syscall, ev_overflow, ev_illegal || violation, ev_addr_fault};

  exc_arbiter #(.XLEN(XLEN)) u_arb (
    .valid(insn_valid), .src(src), .mask(mask),
    .take(trap), .code(code), .grant(grant)
  );

  assign exec_ok = priv_hit && kernel_mode && !trap;

  exc_state #(.XLEN(XLEN)) u_st (
    .clk(clk), .rst_n(rst_n),
    .take(trap), .code(code), .addr_hit(grant[0]),
    .cur_pc(insn_pc), .bad_addr(fault_addr),
    .wr_en(exec_ok && op.is_write), .wr_sel(op.preg), .wr_val(src_gpr_val),
    .ret_en(exec_ok && op.is_ret),
    .rd_sel(op.preg), .rd_val(rd_val),
    .mask(mask), .kernel(kernel_mode)
  );

  assign trap_pc   = trap ? HANDLER_ADDR : '0;
  assign gpr_we    = exec_ok && op.is_read;
  assign gpr_waddr = gpr_we ? op.gpr : '0;
  assign gpr_wdata = gpr_we ? rd_val : '0;

  assert_user_no_gpr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> !gpr_we);
  assert_user_mode_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !trap) |=> !kernel_mode);
  assert_trap_blocks_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !gpr_we);
  assert_idle_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> (!trap && !gpr_we));
endmodule

// File: tb/test_exc_ctrl_unit.sv
`timescale 1ns/1ps
module test_exc_ctrl_unit;
  logic        clk = 0, rst_n = 0, insn_valid = 0;
  logic [31:0] insn = 0, insn_pc = 0, src_gpr_val = 0, fault_addr = 0;
  logic        ev_syscall = 0, ev_overflow = 0, ev_illegal = 0, ev_addr_fault = 0;
  logic        trap, gpr_we, kernel_mode;
  logic [31:0] trap_pc, gpr_wdata;
  logic [4:0]  gpr_waddr;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_epc, m_cause, m_bad, m_mask;
  bit          m_kern;

  always #2 clk = ~clk;

  exc_ctrl_unit i_exc_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .insn_pc(insn_pc),
    .src_gpr_val(src_gpr_val), .ev_syscall(ev_syscall), .ev_overflow(ev_overflow),
    .ev_illegal(ev_illegal), .ev_addr_fault(ev_addr_fault), .fault_addr(fault_addr),
    .trap(trap), .trap_pc(trap_pc), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata), .kernel_mode(kernel_mode)
  );

  function automatic [31:0] mk_rd(input [4:0] rt, input [4:0] pr);
    return {6'b010000, 5'd0, rt, pr, 11'd0};
  endfunction
  function automatic [31:0] mk_wr(input [4:0] rt, input [4:0] pr);
    return {6'b010000, 5'd4, rt, pr, 11'd0};
  endfunction
  function automatic [31:0] mk_ret();
    return {6'b010000, 1'b1, 19'd0, 6'h10};
  endfunction

  function automatic [31:0] m_read(input [4:0] pr);
    case (pr)
      5'd8:  return m_bad;
      5'd12: return m_mask;
      5'd13: return m_cause;
      5'd14: return m_epc;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input [31:0] ins, input [31:0] pc, input [31:0] gv,
                      input bit sy, input bit ov, input bit il, input bit af,
                      input [31:0] fa, input string req);
    bit rd, wr, rt, priv, viol, take, we;
    logic [4:0] code;
    @(negedge clk);
    insn_valid = v; insn = ins; insn_pc = pc; src_gpr_val = gv;
    ev_syscall = sy; ev_overflow = ov; ev_illegal = il; ev_addr_fault = af; fault_addr = fa;
    #1;
    rd = (ins[31:26] == 6'b010000) && (ins[25:21] == 5'd0);
    wr = (ins[31:26] == 6'b010000) && (ins[25:21] == 5'd4);
    rt = (ins[31:26] == 6'b010000) && ins[25] && (ins[5:0] == 6'h10);
    priv = v && (rd || wr || rt);
    viol = priv && !m_kern;
    take = 1; code = 0;
    if (v && af && m_mask[4]) code = 4;
    else if (v && (il || viol) && m_mask[10]) code = 10;
    else if (v && ov && m_mask[12]) code = 12;
    else if (v && sy && m_mask[8]) code = 8;
    else take = 0;
    we = priv && m_kern && !take && rd;
    chk(req, "trap", 32'(trap), 32'(take));
    chk(req, "trap_pc", trap_pc, take ? 32'h8000_0080 : 32'd0);
    chk(req, "gpr_we", 32'(gpr_we), 32'(we));
    chk(req, "gpr_waddr", 32'(gpr_waddr), we ? 32'(ins[20:16]) : 32'd0);
    chk(req, "gpr_wdata", gpr_wdata, we ? m_read(ins[15:11]) : 32'd0);
    chk(req, "kernel_mode", 32'(kernel_mode), 32'(m_kern));
    if (take) begin
      m_epc = pc; m_cause = 32'(code) << 2; m_kern = 1;
      if (code == 4) m_bad = fa;
    end else if (priv && m_kern) begin
      if (wr) case (ins[15:11])
        5'd8: m_bad = gv; 5'd12: m_mask = gv; 5'd13: m_cause = gv; 5'd14: m_epc = gv;
        default: ;
      endcase
      if (rt) m_kern = 0;
    end
  endtask

  task automatic rd_reg(input [4:0] pr, input string req);
    step(1, mk_rd(5'd3, pr), 32'h100, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic wr_reg(input [4:0] pr, input [31:0] val, input string req);
    step(1, mk_wr(5'd7, pr), 32'h104, val, 0, 0, 0, 0, 0, req);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
  endtask

  initial begin
    fork
      begin
        #400000;
        if (!done) begin
          failures++;
          $display("FAIL watchdog actual=timeout expected=completion");
          $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
    m_epc = 0; m_cause = 0; m_bad = 0; m_mask = 0; m_kern = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    chk("R1", "reset kernel", 32'(kernel_mode), 32'd1);
    chk("R1", "reset trap", 32'(trap), 32'd0);
    // R1/R2: all registers zero, unknown number reads 0
    rd_reg(5'd8, "R1"); rd_reg(5'd12, "R1"); rd_reg(5'd13, "R1"); rd_reg(5'd14, "R1");
    // R4: sources masked off at reset
    step(1, 0, 32'h200, 0, 1, 1, 1, 1, 32'hdead0000, "R4");
    rd_reg(5'd13, "R4");
    // R3/R2: writes and reads
    wr_reg(5'd14, 32'h0000_1234, "R3"); rd_reg(5'd14, "R2");
    wr_reg(5'd5, 32'hffff_ffff, "R3"); rd_reg(5'd5, "R2");
    wr_reg(5'd12, 32'h0000_1510, "R3"); rd_reg(5'd12, "R2");
    // R5: overflow trap
    step(1, 0, 32'h400, 0, 0, 1, 0, 0, 0, "R5");
    rd_reg(5'd13, "R5"); rd_reg(5'd14, "R5");
    // R6/R7: priority
    step(1, 0, 32'h500, 0, 1, 1, 1, 1, 32'h0bad_0040, "R6");
    rd_reg(5'd13, "R6"); rd_reg(5'd8, "R7");
    step(1, 0, 32'h504, 0, 1, 1, 1, 0, 32'h1111_1111, "R6");
    step(1, 0, 32'h508, 0, 1, 1, 0, 0, 32'h2222_2222, "R6");
    step(1, 0, 32'h50c, 0, 1, 0, 0, 0, 32'h3333_3333, "R7");
    rd_reg(5'd13, "R6"); rd_reg(5'd8, "R7");
    // R4: partial mask skips a disabled higher source
    wr_reg(5'd12, 32'h0000_1100, "R4");
    step(1, 0, 32'h600, 0, 0, 1, 0, 1, 32'h4444_4444, "R4");
    rd_reg(5'd8, "R4");
    // R11: sources ignored when no instruction
    step(0, mk_ret(), 32'h700, 0, 1, 1, 1, 1, 32'h5555_5555, "R11");
    idle(); rd_reg(5'd14, "R11");
    // R10: trap wins over same-cycle privileged write and return
    wr_reg(5'd12, 32'h0000_1110, "R3");
    step(1, mk_wr(5'd2, 5'd12), 32'h800, 32'h0, 0, 1, 0, 0, 0, "R10");
    rd_reg(5'd12, "R10");
    step(1, mk_ret(), 32'h804, 0, 1, 0, 0, 0, 0, "R10");
    step(1, mk_rd(5'd4, 5'd14), 32'h808, 0, 0, 0, 0, 1, 32'h6666_0000, "R10");
    // R9: return to user
    step(1, mk_ret(), 32'h900, 0, 0, 0, 0, 0, 0, "R9");
    idle();
    // R8: user-mode privileged ops with illegal source masked off
    step(1, mk_wr(5'd2, 5'd12), 32'ha00, 32'h0, 0, 0, 0, 0, 0, "R8");
    step(1, mk_rd(5'd2, 5'd12), 32'ha04, 0, 0, 0, 0, 0, 0, "R8");
    step(1, mk_ret(), 32'ha08, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 32'ha0c, 0, 1, 0, 0, 0, 0, "R5");
    rd_reg(5'd12, "R8");
    // R8: with illegal enabled, user access traps
    wr_reg(5'd12, 32'h0000_1510, "R3");
    step(1, mk_ret(), 32'hb00, 0, 0, 0, 0, 0, 0, "R9");
    step(1, mk_rd(5'd9, 5'd14), 32'hb04, 0, 0, 0, 0, 0, 0, "R8");
    rd_reg(5'd13, "R8"); rd_reg(5'd14, "R8");
    idle();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule